// File: doc/BRIEF.md
# Front-Panel Three-Wire Command Port

This block is the slave side of a slow three-wire link between a host controller and a front-panel controller. The host drives a serial clock, a strobe and one bidirectional data line. All three pins are asynchronous to the fast system clock. The block samples them into that clock domain and looks for rising edges there.

While receiving, the block collects bits into a frame. On each strobe rising edge it reads the newest four bits as a command. Depending on the command, it latches one of two 40-bit display halves. Half A also carries an LED bit. A command may also request a key scan. In that case a later strobe switches the data line to transmit, and the 30-bit key word held from the last completed scan is clocked out to the host. One more strobe returns the line to receive.

The display outputs, the LED drive and the scan-start pulse go to the panel logic. The scan engine returns its key word together with a completion level.

Top module: `fp_serial_if`

## Requirements
- R1: Each host pin passes through two flip-flop stages. An edge of host_clk_i or host_load_i first sampled at system edge N acts on the registered outputs at system edge N+2, which is the third system edge counting from the one that first sees it.
- R2: In receive mode, each rising edge of host_clk_i shifts in host_data_i. Rising edges of host_clk_i while host_load_i is high shift nothing.
- R3: On a host_load_i rising edge, the four most recent bits form the command, and the most recent bit is its MSB. 4'b0010 loads half A. 4'b0011 loads half B. 4'b0110 loads half A and requests a scan. 4'b0111 loads half B and requests a scan.
- R4: A half-A frame is 45 bits: the LED bit, then 40 display bits with display bit 39 first and bit 0 last, then the command. A half-B frame is 44 bits, laid out the same way without the LED bit. A half-B load leaves the LED state unchanged.
- R5: A scan request raises scan_start_o for exactly one system cycle. Codes 4'b0100, 4'b0101 and 4'b1100 to 4'b1111 request a scan only.
- R6: Codes 4'b0000, 4'b0001, 4'b1000 to 4'b1011 change no display, LED or scan output.
- R7: led_oe_o is 0 from reset until the first half-A load and stays 1 after it. led_n_o is 0 when the stored LED bit is 1.
- R8: After an honoured scan request, the next host_load_i rising edge sets host_data_oe_o and clears host_data_o, and does not decode a command. Each following host_clk_i rising edge drives the next key bit, key bit 0 first through bit 29, and 0 after that. The next host_load_i rising edge clears host_data_oe_o.
- R9: disp_valid_o goes to 1 on the first display load and stays 1. A scan request is honoured only if a display load has already happened or happens in the same command. A scan-only command before that has no effect, and neither does the strobe after it.
- R10: key_word_i is captured when scan_done_i rises. A readout returns the word captured most recently, even if key_word_i has changed since.
- R11: After reset, both display halves are 0, and disp_valid_o, led_oe_o, host_data_oe_o and scan_start_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_clk_i | input | 1 | Host serial clock, asynchronous |
| host_load_i | input | 1 | Host strobe, asynchronous |
| host_data_i | input | 1 | Serial data from host |
| host_data_o | output | 1 | Serial data to host |
| host_data_oe_o | output | 1 | Drive enable for the data line |
| key_word_i | input | KEY_BITS | Key word from the scan engine |
| scan_done_i | input | 1 | Scan-complete level from the scan engine |
| scan_start_o | output | 1 | One-cycle scan request |
| disp_a_o | output | DISP_BITS | Display half A |
| disp_b_o | output | DISP_BITS | Display half B |
| disp_valid_o | output | 1 | At least one display half has been loaded |
| led_n_o | output | 1 | LED drive, active low |
| led_oe_o | output | 1 | LED drive enable |

## Verification
The bench sends a scan-only command before any display load, and then a bare strobe. A design that skipped the ordering rule would pulse scan_start_o and turn the data line around. Clock pulses during a high strobe are followed by a second bare strobe. If they were wrongly shifted in, the tail would decode as a scan request instead of a half-A reload.

Key words are changed without a scan-done edge. A design that sampled key_word_i live would return the new word instead of the held one. The cycle of the first display update after a strobe is measured to catch a missing or extra synchronizer stage. Frames of 44 and 45 bits are mixed to catch a design that places the display bits by frame length or disturbs the LED on a half-B load.

// File: rtl/fpsi_pkg.sv
package fpsi_pkg;
  localparam int CMD_W = 4;

  typedef enum logic {MODE_RX = 1'b0, MODE_TX = 1'b1} io_mode_e;

  typedef struct packed {
    logic load_a;
    logic load_b;
    logic want_keys;
  } cmd_act_t;

  // newest bit sits at tail[0] and is the command MSB
  function automatic logic [CMD_W-1:0] tail_to_cmd(input logic [CMD_W-1:0] tail);
    logic [CMD_W-1:0] c;
    for (int i = 0; i < CMD_W; i++) c[CMD_W-1-i] = tail[i];
    return c;
  endfunction

  function automatic cmd_act_t decode_cmd(input logic [CMD_W-1:0] c);
    cmd_act_t a;
    a = '0;
    unique case (c)
      4'b0010: a.load_a = 1'b1;
      4'b0011: a.load_b = 1'b1;
      4'b0110: begin a.load_a = 1'b1; a.want_keys = 1'b1; end
      4'b0111: begin a.load_b = 1'b1; a.want_keys = 1'b1; end
      4'b0100, 4'b0101,
      4'b1100, 4'b1101, 4'b1110, 4'b1111: a.want_keys = 1'b1;
      default: a = '0;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/fpsi_sync.sv
module fpsi_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_i[g]};
    end
    assign level_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/fpsi_rise_det.sv
module fpsi_rise_det #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] last_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= level_i;
  end
  assign rise_o = level_i & ~last_q;
endmodule

// File: rtl/fpsi_rx_shift.sv
module fpsi_rx_shift #(
  parameter int DISP_BITS = 40,
  parameter int CMD_BITS  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic                 bit_i,
  output logic [DISP_BITS-1:0] disp_o,
  output logic                 led_o,
  output logic [CMD_BITS-1:0]  tail_o
);
  localparam int FRAME_BITS = DISP_BITS + CMD_BITS + 1;
  logic [FRAME_BITS-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (shift_en) sr_q <= {sr_q[FRAME_BITS-2:0], bit_i};
  end

  assign tail_o = sr_q[CMD_BITS-1:0];
  assign disp_o = sr_q[CMD_BITS +: DISP_BITS];
  assign led_o  = sr_q[FRAME_BITS-1];
endmodule

// File: rtl/fpsi_tx_shift.sv
module fpsi_tx_shift #(
  parameter int KEY_BITS = 30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_en,
  input  logic                shift_en,
  input  logic [KEY_BITS-1:0] key_i,
  output logic                data_o
);
  logic [KEY_BITS-1:0] osr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osr_q  <= '0;
      data_o <= 1'b0;
    end else if (load_en) begin
      osr_q  <= key_i;
      data_o <= 1'b0;
    end else if (shift_en) begin
      data_o <= osr_q[0];
      osr_q  <= {1'b0, osr_q[KEY_BITS-1:1]};
    end
  end
endmodule

// File: rtl/fp_serial_if.sv
module fp_serial_if
  import fpsi_pkg::*;
#(
  parameter int DISP_BITS   = 40,
  parameter int KEY_BITS    = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_clk_i,
  input  logic                 host_load_i,
  input  logic                 host_data_i,
  output logic                 host_data_o,
  output logic                 host_data_oe_o,
  input  logic [KEY_BITS-1:0]  key_word_i,
  input  logic                 scan_done_i,
  output logic                 scan_start_o,
  output logic [DISP_BITS-1:0] disp_a_o,
  output logic [DISP_BITS-1:0] disp_b_o,
  output logic                 disp_valid_o,
  output logic                 led_n_o,
  output logic                 led_oe_o
);
  localparam int CMD_BITS = CMD_W;

  // synchronized pin levels: [0] clock, [1] strobe, [2] data
  logic [2:0] pin_lvl;
  logic [1:0] pin_rise;

  fpsi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({host_data_i, host_load_i, host_clk_i}),
    .level_o (pin_lvl)
  );

  fpsi_rise_det #(.WIDTH(2)) u_rise (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (pin_lvl[1:0]),
    .rise_o  (pin_rise)
  );

  io_mode_e              mode_q;
  logic                  pend_q;
  logic                  valid_q;
  logic                  led_bit_q;
  logic                  led_en_q;
  logic                  scan_q;
  logic                  done_q;
  logic [KEY_BITS-1:0]   key_hold_q;
  logic [DISP_BITS-1:0]  disp_a_q;
  logic [DISP_BITS-1:0]  disp_b_q;

  // named internal events
  logic                  clk_rise_w;
  logic                  load_rise_w;
  logic                  rx_shift_w;
  logic                  tx_shift_w;
  logic                  decode_en_w;
  logic                  key_honor_w;
  logic                  tx_enter_w;
  logic                  tx_leave_w;
  logic [DISP_BITS-1:0]  rx_disp_w;
  logic                  rx_led_w;
  logic [CMD_BITS-1:0]   rx_tail_w;
  logic [CMD_BITS-1:0]   cmd_w;
  cmd_act_t              act_w;

  assign clk_rise_w  = pin_rise[0] & ~pin_lvl[1];
  assign load_rise_w = pin_rise[1];
  assign rx_shift_w  = clk_rise_w & (mode_q == MODE_RX);
  assign tx_shift_w  = clk_rise_w & (mode_q == MODE_TX);

  fpsi_rx_shift #(.DISP_BITS(DISP_BITS), .CMD_BITS(CMD_BITS)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (rx_shift_w),
    .bit_i    (pin_lvl[2]),
    .disp_o   (rx_disp_w),
    .led_o    (rx_led_w),
    .tail_o   (rx_tail_w)
  );

  assign cmd_w       = tail_to_cmd(rx_tail_w);
  assign act_w       = decode_cmd(cmd_w);
  assign decode_en_w = load_rise_w & (mode_q == MODE_RX) & ~pend_q;
  assign key_honor_w = decode_en_w & act_w.want_keys &
                       (valid_q | act_w.load_a | act_w.load_b);
  assign tx_enter_w  = load_rise_w & (mode_q == MODE_RX) & pend_q;
  assign tx_leave_w  = load_rise_w & (mode_q == MODE_TX);

  fpsi_tx_shift #(.KEY_BITS(KEY_BITS)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (tx_enter_w),
    .shift_en (tx_shift_w),
    .key_i    (key_hold_q),
    .data_o   (host_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_RX;
      pend_q    <= 1'b0;
      valid_q   <= 1'b0;
      led_bit_q <= 1'b0;
      led_en_q  <= 1'b0;
      scan_q    <= 1'b0;
      disp_a_q  <= '0;
      disp_b_q  <= '0;
    end else begin
      scan_q <= key_honor_w;
      if (tx_leave_w) mode_q <= MODE_RX;
      if (tx_enter_w) begin
        mode_q <= MODE_TX;
        pend_q <= 1'b0;
      end
      if (key_honor_w) pend_q <= 1'b1;
      if (decode_en_w && act_w.load_a) begin
        disp_a_q  <= rx_disp_w;
        led_bit_q <= rx_led_w;
        led_en_q  <= 1'b1;
        valid_q   <= 1'b1;
      end
      if (decode_en_w && act_w.load_b) begin
        disp_b_q <= rx_disp_w;
        valid_q  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q     <= 1'b0;
      key_hold_q <= '0;
    end else begin
      done_q <= scan_done_i;
      if (scan_done_i && !done_q) key_hold_q <= key_word_i;
    end
  end

  assign host_data_oe_o = (mode_q == MODE_TX);
  assign scan_start_o   = scan_q;
  assign disp_a_o       = disp_a_q;
  assign disp_b_o       = disp_b_q;
  assign disp_valid_o   = valid_q;
  assign led_n_o        = ~led_bit_q;
  assign led_oe_o       = led_en_q;
endmodule

// File: rtl/fpsi_checker.sv
module fpsi_checker #(
  parameter int DISP_BITS = 40
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 scan_start_o,
  input logic [DISP_BITS-1:0] disp_a_o,
  input logic                 disp_valid_o,
  input logic                 led_oe_o,
  input logic                 host_data_oe_o,
  input logic                 host_data_o,
  input logic                 load_rise_w,
  input logic                 clk_rise_w
);
  // R5
  scan_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start_o |=> !scan_start_o);

  // R5
  scan_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start_o |-> $past(load_rise_w));

  // R3
  disp_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_rise_w |=> $stable(disp_a_o));

  // R7
  led_oe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    led_oe_o |=> led_oe_o);

  // R9
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid_o |=> disp_valid_o);

  // R8
  oe_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(host_data_oe_o) |-> $past(load_rise_w));

  // R8
  tx_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_rise_w && !load_rise_w) |=> $stable(host_data_o));
endmodule

bind fp_serial_if fpsi_checker #(.DISP_BITS(DISP_BITS)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .scan_start_o   (scan_start_o),
  .disp_a_o       (disp_a_o),
  .disp_valid_o   (disp_valid_o),
  .led_oe_o       (led_oe_o),
  .host_data_oe_o (host_data_oe_o),
  .host_data_o    (host_data_o),
  .load_rise_w    (load_rise_w),
  .clk_rise_w     (clk_rise_w)
);

// File: tb/fp_serial_if_tb.sv
`timescale 1ns/1ps
module fp_serial_if_tb_top;
  localparam int HP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hc = 1'b0, hl = 1'b0, hd = 1'b0, sd = 1'b0;
  logic [29:0] kw = '0;
  logic        host_data_o, host_data_oe_o, scan_start_o;
  logic [39:0] disp_a_o, disp_b_o;
  logic        disp_valid_o, led_n_o, led_oe_o;

  int checks = 0;
  int errors = 0;
  int fail_prints = 0;
  int scan_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fp_serial_if dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_clk_i(hc), .host_load_i(hl), .host_data_i(hd),
    .host_data_o(host_data_o), .host_data_oe_o(host_data_oe_o),
    .key_word_i(kw), .scan_done_i(sd), .scan_start_o(scan_start_o),
    .disp_a_o(disp_a_o), .disp_b_o(disp_b_o), .disp_valid_o(disp_valid_o),
    .led_n_o(led_n_o), .led_oe_o(led_oe_o)
  );

  // ---------------- behavioural reference ----------------
  logic [3:0] h_c, h_l, h_d;   // [0] = sampled now, [k] = k edges ago
  logic m_prev_done;
  logic mq[$];
  logic [39:0] m_a, m_b;
  logic [29:0] m_hold;
  logic m_valid, m_led, m_led_en, m_scan, m_pend, m_tx, m_data;
  int   m_idx;

  function automatic logic mget(int k);
    if (k < mq.size()) return mq[mq.size()-1-k];
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      h_c = '0; h_l = '0; h_d = '0; m_prev_done = 0; mq.delete();
      m_a = '0; m_b = '0; m_hold = '0; m_valid = 0; m_led = 0; m_led_en = 0;
      m_scan = 0; m_pend = 0; m_tx = 0; m_data = 0; m_idx = 0;
    end else begin
      h_c = {h_c[2:0], hc}; h_l = {h_l[2:0], hl}; h_d = {h_d[2:0], hd};
      m_scan = 0;
      if (h_l[2] && !h_l[3]) begin
        if (m_tx) m_tx = 0;
        else if (m_pend) begin m_tx = 1; m_pend = 0; m_data = 0; m_idx = 0; end
        else begin
          int c;
          bit la, lb, wk;
          c = {mget(0), mget(1), mget(2), mget(3)};
          la = (c == 2 || c == 6);
          lb = (c == 3 || c == 7);
          wk = (c & 4) != 0;
          if (wk && (m_valid || la || lb)) begin m_scan = 1; m_pend = 1; end
          if (la) begin
            for (int j = 0; j < 40; j++) m_a[j] = mget(4 + j);
            m_led = mget(44); m_led_en = 1; m_valid = 1;
          end
          if (lb) begin
            for (int j = 0; j < 40; j++) m_b[j] = mget(4 + j);
            m_valid = 1;
          end
        end
      end else if (h_c[2] && !h_c[3] && !h_l[2]) begin
        if (m_tx) begin
          m_data = (m_idx < 30) ? m_hold[m_idx] : 1'b0;
          m_idx++;
        end else begin
          mq.push_back(h_d[2]);
          if (mq.size() > 64) void'(mq.pop_front());
        end
      end
      if (sd && !m_prev_done) m_hold = kw;
      m_prev_done = sd;
    end
  end

  task automatic note_fail(input string tag, input logic [63:0] act, input logic [63:0] exp);
    errors++;
    if (fail_prints < 20) begin
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      fail_prints++;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (disp_a_o !== m_a)             note_fail("R4 disp_a", 64'(disp_a_o), 64'(m_a));
      if (disp_b_o !== m_b)             note_fail("R4 disp_b", 64'(disp_b_o), 64'(m_b));
      if (disp_valid_o !== m_valid)     note_fail("R9 valid", 64'(disp_valid_o), 64'(m_valid));
      if (led_oe_o !== m_led_en)        note_fail("R7 led_oe", 64'(led_oe_o), 64'(m_led_en));
      if (led_n_o !== !m_led)           note_fail("R7 led_n", 64'(led_n_o), 64'(!m_led));
      if (scan_start_o !== m_scan)      note_fail("R5 scan", 64'(scan_start_o), 64'(m_scan));
      if (host_data_oe_o !== m_tx)      note_fail("R8 oe", 64'(host_data_oe_o), 64'(m_tx));
      if (host_data_o !== m_data)       note_fail("R8 data", 64'(host_data_o), 64'(m_data));
    end
  end

  always @(posedge clk) if (rst_n && scan_start_o) scan_cnt++;

  // ---------------- directed helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) note_fail(tag, act, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [63:0] f, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      hd = f[i]; wait_cyc(HP); hc = 1; wait_cyc(HP); hc = 0;
    end
    hd = 0; wait_cyc(HP);
  endtask

  task automatic strobe();
    hl = 1; wait_cyc(2 * HP); hl = 0; wait_cyc(2 * HP);
  endtask

  task automatic read_keys(output logic [29:0] v);
    for (int i = 0; i < 30; i++) begin
      hc = 1; wait_cyc(HP); v[i] = host_data_o; hc = 0; wait_cyc(HP);
    end
  endtask

  task automatic scan_complete(input logic [29:0] w);
    kw = w; sd = 1; wait_cyc(3); sd = 0; wait_cyc(3);
  endtask

  function automatic logic [63:0] frame_a(input logic led, input logic [39:0] d, input logic [3:0] c);
    return {19'd0, led, d, c[0], c[1], c[2], c[3]};
  endfunction
  function automatic logic [63:0] frame_b(input logic [39:0] d, input logic [3:0] c);
    return {20'd0, d, c[0], c[1], c[2], c[3]};
  endfunction
  function automatic logic [63:0] cmd_only(input logic [3:0] c);
    return {60'd0, c[0], c[1], c[2], c[3]};
  endfunction

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 190000 && !finished) begin
        note_fail("watchdog", 64'(wd), 64'd0);
        finish_run();
      end
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [29:0] got;
    int sc;
    wait_cyc(5); rst_n = 1; wait_cyc(2);

    // R11 reset state
    chk(disp_a_o == 0 && disp_b_o == 0, "R11 displays", 64'(disp_a_o), 0);
    chk(!disp_valid_o && !led_oe_o, "R11 valid/led_oe", {disp_valid_o, led_oe_o}, 0);
    chk(!host_data_oe_o && !scan_start_o, "R11 oe/scan", {host_data_oe_o, scan_start_o}, 0);

    // R9 scan-only before any display load, then a bare strobe
    send(cmd_only(4'b0100), 4); strobe(); strobe();
    chk(scan_cnt == 0, "R9 early scan ignored", 64'(scan_cnt), 0);
    chk(!host_data_oe_o, "R9 no turnaround", 64'(host_data_oe_o), 0);
    chk(!disp_valid_o, "R9 valid still low", 64'(disp_valid_o), 0);

    // R6 unused code with a full frame
    send(frame_a(1'b1, 40'hFF_FFFF_FFFF, 4'b0001), 45); strobe();
    chk(disp_a_o == 0 && !led_oe_o, "R6 unused code", 64'(disp_a_o), 0);

    // R3/R4/R7 half A load, with R1 latency measurement
    send(frame_a(1'b1, 40'hA5_1234_C3F0, 4'b0010), 45);
    hl = 1; wait_cyc(2);
    chk(disp_a_o == 0, "R1 not yet updated", 64'(disp_a_o), 0);
    wait_cyc(1);
    chk(disp_a_o == 40'hA5_1234_C3F0, "R1 updated on third edge", 64'(disp_a_o), 64'h00A5_1234_C3F0);
    wait_cyc(2 * HP); hl = 0; wait_cyc(2 * HP);
    chk(led_oe_o && !led_n_o, "R7 led on", {led_oe_o, led_n_o}, 2'b10);
    chk(disp_valid_o, "R9 valid set", 64'(disp_valid_o), 1);

    // R2 clock pulses while strobe high must not shift
    sc = scan_cnt;
    hl = 1; wait_cyc(HP);
    for (int i = 0; i < 5; i++) begin hd = 1; hc = 1; wait_cyc(3); hc = 0; wait_cyc(3); end
    hd = 0; wait_cyc(HP); hl = 0; wait_cyc(2 * HP);
    strobe();
    chk(scan_cnt == sc, "R2 no shift under strobe", 64'(scan_cnt), 64'(sc));
    chk(disp_a_o == 40'hA5_1234_C3F0, "R2 half A intact", 64'(disp_a_o), 64'h00A5_1234_C3F0);

    // R4 half B, 44 bits; LED untouched
    send(frame_b(40'h0F_EDCB_A987, 4'b0011), 44); strobe();
    chk(disp_b_o == 40'h0F_EDCB_A987, "R4 half B", 64'(disp_b_o), 64'h000F_EDCB_A987);
    chk(!led_n_o && disp_a_o == 40'hA5_1234_C3F0, "R4 B leaves A/LED", 64'(led_n_o), 0);

    // R10/R8 held key word, load A + scan
    scan_complete(30'h2AC3_1F5B);
    sc = scan_cnt;
    send(frame_a(1'b0, 40'h33_CC55_AA01, 4'b0110), 45); strobe();
    chk(scan_cnt == sc + 1, "R5 scan pulse", 64'(scan_cnt), 64'(sc + 1));
    chk(disp_a_o == 40'h33_CC55_AA01 && led_n_o, "R3 load A + scan", 64'(disp_a_o), 64'h0033_CC55_AA01);
    strobe();
    chk(host_data_oe_o, "R8 output mode", 64'(host_data_oe_o), 1);
    read_keys(got);
    chk(got == 30'h2AC3_1F5B, "R8 key bits", 64'(got), 64'h2AC3_1F5B);
    hc = 1; wait_cyc(HP); chk(host_data_o == 0, "R8 past end", 64'(host_data_o), 0);
    hc = 0; wait_cyc(HP);
    strobe();
    chk(!host_data_oe_o, "R8 back to input", 64'(host_data_oe_o), 0);

    // R10 new word without completion edge -> old word
    kw = 30'h1555_5555; wait_cyc(4);
    send(cmd_only(4'b1100), 4); strobe(); strobe();
    read_keys(got);
    chk(got == 30'h2AC3_1F5B, "R10 held word", 64'(got), 64'h2AC3_1F5B);
    strobe();

    scan_complete(30'h0123_4567);
    send(cmd_only(4'b0101), 4); strobe(); strobe();
    read_keys(got);
    chk(got == 30'h0123_4567, "R10 fresh word", 64'(got), 64'h0123_4567);
    strobe();

    // R5 load B + scan
    sc = scan_cnt;
    send(frame_b(40'h80_0000_0001, 4'b0111), 44); strobe();
    chk(scan_cnt == sc + 1 && disp_b_o == 40'h80_0000_0001, "R5 load B + scan", 64'(disp_b_o), 64'h0080_0000_0001);
    strobe(); strobe();
    chk(!host_data_oe_o, "R8 closed", 64'(host_data_oe_o), 0);

    wait_cyc(20);
    finish_run();
  end
endmodule